// File: doc/BRIEF.md
# Tester-to-Bus Vector Controller

This block lets an external tester take over an internal memory-mapped bus through a shared 32-bit port. In normal operation the block stays passive. When the tester presents the entry code on two request pins, the block grants test mode by raising its acknowledge line. From then on, every cycle in which the acknowledge is high, the block samples the two-pin code. That code names the kind of vector the tester applies in the following cycle: an address or turnaround vector, a write vector, a read vector, or the exit request.

Write and read vectors become single transfers on an internal master port. The request side of that port is valid/ready. Once valid is raised, address, write data and direction stay frozen until ready is seen, and the master never withdraws a request. The block keeps its acknowledge low for as long as the transfer is outstanding, and the tester must hold its vector for that whole time. The shared port is modelled as separate input, output and output-enable signals. The block drives the port only with read results. It also makes sure that a direction change never happens without a spare cycle in between.

Top module: `test_bus_ctrl`

## Requirements
- R1: After reset, `grant_ack`, `tb_oe` and `m_valid` are low and the block is in normal mode.
- R2: In normal mode, `req_a`=1 with `req_b`=0 sampled at a clock edge enters test mode: `grant_ack` is high in the next cycle and `tb_oe` is low.
- R3: In normal mode, codes `req_a,req_b` = 0,0 and 0,1 leave `grant_ack` low and do not enter test mode.
- R4: In test mode the request pair is sampled only in cycles where `grant_ack` is high. Code changes while `grant_ack` is low have no effect.
- R5: Code 1,1 (not directly following a read) makes the next cycle an address vector. `tb_in` in that cycle is loaded into the address register, `grant_ack` stays high, and the next transfer uses that address.
- R6: Code 1,0 makes the next vector a write. `grant_ack` drops in the following cycle, and a transfer with `m_write`=1, `m_wdata` equal to the `tb_in` held by the tester, and the current address is issued. After each completed transfer the address grows by 4.
- R7: Code 0,1 makes the next vector a read. A transfer with `m_write`=0 is issued. In the cycle where `grant_ack` returns high, `tb_out` holds the returned `m_rdata` and `tb_oe` is high.
- R8: While `m_valid` is high, `grant_ack` is low. `grant_ack` rises in the cycle after the cycle where `m_valid` and `m_ready` are both high.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_wdata` and `m_write` hold their values.
- R10: `tb_oe` rises only after a read transfer completes. It stays high across back-to-back reads and falls in the cycle after any non-read code is sampled.
- R11: Turnaround after a read: a 1,1 code sampled while `tb_oe` is high makes the next cycle a turnaround that does not load the address. For a write code sampled while `tb_oe` is high, `tb_in` is ignored for the vector's first cycle and captured one cycle later. While a write transfer is outstanding, `tb_oe` is low.
- R12: Code 0,0 sampled in test mode returns to normal mode. In the next cycle `grant_ack`, `tb_oe` and `m_valid` are low, and the address register keeps its value for the next test session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_a | input | 1 | Request code, first bit |
| req_b | input | 1 | Request code, second bit |
| grant_ack | output | 1 | Test mode granted / vector complete |
| tb_in | input | DW | Shared port, tester-driven value |
| tb_out | output | DW | Shared port, block-driven value (read data) |
| tb_oe | output | 1 | Shared port output enable |
| m_valid | output | 1 | Master request valid |
| m_ready | input | 1 | Master request accepted |
| m_addr | output | AW | Master address |
| m_wdata | output | DW | Master write data |
| m_write | output | 1 | Master direction, 1 = write |
| m_rdata | input | DW | Read data, valid with the ready of a read |

## Verification
The bench aims at the cycles where the shared port changes direction. These are a write or an address vector straight after a read. A design without the extra cycle would capture the junk value driven during turnaround, or would load the address from a turnaround cycle. Reads and writes are retired with ready delayed by random amounts, and the request pins toggle randomly while the acknowledge is low. A design that samples codes outside acknowledge-high cycles would then leave test mode or start stray transfers. A design that raises the acknowledge too early would show up as a stale address or stale read data. The bench also checks that the reserved code in normal mode never grants the port, and that the address survives an exit and re-entry.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  // request code as {req_a, req_b} while test mode is granted
  typedef enum logic [1:0] {
    K_EXIT  = 2'b00,
    K_READ  = 2'b01,
    K_WRITE = 2'b10,
    K_ADDR  = 2'b11
  } kind_e;

  // vector being applied in the current cycle
  typedef enum logic [2:0] {
    V_IDLE  = 3'd0,
    V_ADDR  = 3'd1,
    V_TURN  = 3'd2,
    V_WRITE = 3'd3,
    V_READ  = 3'd4
  } vec_e;
endpackage

// File: rtl/tbc_decode.sv
module tbc_decode
  import tbc_pkg::*;
(
  input  logic  req_a,
  input  logic  req_b,
  output kind_e kind,
  output logic  enter_req
);
  always_comb begin
    case ({req_a, req_b})
      2'b11:   kind = K_ADDR;
      2'b10:   kind = K_WRITE;
      2'b01:   kind = K_READ;
      default: kind = K_EXIT;
    endcase
  end

  // only A-high/B-low asks for entry; A-low/B-high stays reserved
  assign enter_req = req_a & ~req_b;
endmodule

// File: rtl/tbc_addr_ctr.sv
module tbc_addr_ctr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          bump,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] StepV = AW'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= load_val;
    else if (bump)  addr <= addr + StepV;
  end
endmodule

// File: rtl/tbc_master_if.sv
module tbc_master_if #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_wr,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  output logic          m_write,
  output logic          done
);
  assign done = m_valid & m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
      m_write <= 1'b0;
    end else if (launch) begin
      m_valid <= 1'b1;
      m_addr  <= addr_in;
      m_wdata <= launch_wr ? data_in : '0;
      m_write <= launch_wr;
    end else if (done) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tbc_bus_dir.sv
module tbc_bus_dir #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_done,
  input  logic [DW-1:0] rd_data,
  input  logic          release_bus,
  output logic          oe,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe       <= 1'b0;
      out_data <= '0;
    end else if (rd_done) begin
      oe       <= 1'b1;
      out_data <= rd_data;
    end else if (release_bus) begin
      oe       <= 1'b0;
    end
  end
endmodule

// File: rtl/test_bus_ctrl.sv
module test_bus_ctrl
  import tbc_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int ADDR_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_a,
  input  logic          req_b,
  output logic          grant_ack,
  input  logic [DW-1:0] tb_in,
  output logic [DW-1:0] tb_out,
  output logic          tb_oe,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  output logic          m_write,
  input  logic [DW-1:0] m_rdata
);
  logic          in_test_q;
  logic          ack_q;
  logic          skip_q;
  vec_e          cur_q;
  kind_e         kind;
  logic          enter_req;
  logic          sample;
  logic          launch;
  logic          done;
  logic          addr_load;
  logic [AW-1:0] addr;

  tbc_decode u_dec (
    .req_a     (req_a),
    .req_b     (req_b),
    .kind      (kind),
    .enter_req (enter_req)
  );

  assign sample    = in_test_q & ack_q;
  assign addr_load = sample & (cur_q == V_ADDR);
  assign launch    = in_test_q & ~ack_q & ~m_valid & ~skip_q &
                     ((cur_q == V_WRITE) | (cur_q == V_READ));

  tbc_addr_ctr #(.AW(AW), .STEP(ADDR_STEP)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (addr_load),
    .load_val (tb_in[AW-1:0]),
    .bump     (done),
    .addr     (addr)
  );

  tbc_master_if #(.AW(AW), .DW(DW)) u_mst (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .launch_wr (cur_q == V_WRITE),
    .addr_in   (addr),
    .data_in   (tb_in),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .m_write   (m_write),
    .done      (done)
  );

  tbc_bus_dir #(.DW(DW)) u_dir (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_done     (done & ~m_write),
    .rd_data     (m_rdata),
    .release_bus (sample & (kind != K_READ)),
    .oe          (tb_oe),
    .out_data    (tb_out)
  );

  // mode / acknowledge sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_test_q <= 1'b0;
      ack_q     <= 1'b0;
      skip_q    <= 1'b0;
      cur_q     <= V_IDLE;
    end else if (!in_test_q) begin
      if (enter_req) begin
        in_test_q <= 1'b1;
        ack_q     <= 1'b1;
        cur_q     <= V_IDLE;
      end
    end else if (ack_q) begin
      case (kind)
        K_ADDR:  cur_q <= tb_oe ? V_TURN : V_ADDR;
        K_WRITE: begin
          cur_q  <= V_WRITE;
          ack_q  <= 1'b0;
          skip_q <= tb_oe;
        end
        K_READ: begin
          cur_q <= V_READ;
          ack_q <= 1'b0;
        end
        default: begin
          in_test_q <= 1'b0;
          ack_q     <= 1'b0;
          cur_q     <= V_IDLE;
        end
      endcase
    end else begin
      if (skip_q) skip_q <= 1'b0;
      if (done) begin
        ack_q <= 1'b1;
        cur_q <= V_IDLE;
      end
    end
  end

  assign grant_ack = ack_q;
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_a,
  input logic          req_b,
  input logic          grant_ack,
  input logic          tb_oe,
  input logic          m_valid,
  input logic          m_ready,
  input logic [AW-1:0] m_addr,
  input logic [DW-1:0] m_wdata,
  input logic          m_write,
  input logic          in_test
);
  p_quiet_normal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_test |-> (!grant_ack && !tb_oe && !m_valid));

  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_test && req_a && !req_b) |=> (in_test && grant_ack && !tb_oe));

  p_no_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_test && !(req_a && !req_b)) |=> !in_test);

  p_ack_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !grant_ack);

  p_ack_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |=> grant_ack);

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=>
      (m_valid && $stable(m_addr) && $stable(m_wdata) && $stable(m_write)));

  p_oe_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tb_oe) |-> $past(m_valid && m_ready && !m_write));

  p_no_drive_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_write) |-> !tb_oe);

  p_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_test && grant_ack && !req_a && !req_b) |=> !in_test);

  p_ignore_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_test && !grant_ack) |=> in_test);
endmodule

bind test_bus_ctrl tbc_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_a     (req_a),
  .req_b     (req_b),
  .grant_ack (grant_ack),
  .tb_oe     (tb_oe),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_addr    (m_addr),
  .m_wdata   (m_wdata),
  .m_write   (m_write),
  .in_test   (in_test_q)
);

// File: tb/test_bus_ctrl_tb.sv
`timescale 1ns/1ps
module test_bus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_a, req_b;
  logic        grant_ack;
  logic [31:0] tb_in, tb_out;
  logic        tb_oe;
  logic        m_valid, m_ready, m_write;
  logic [31:0] m_addr, m_wdata, m_rdata;

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] exp_addr = '0;
  bit          last_rd = 1'b0;
  logic [31:0] hs_addr;

  always #2 clk = ~clk;

  test_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b),
    .grant_ack(grant_ack), .tb_in(tb_in), .tb_out(tb_out), .tb_oe(tb_oe),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_write(m_write), .m_rdata(m_rdata)
  );

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic enter_test();
    req_a = 1'b1; req_b = 1'b0;
    @(negedge clk);
    chk("R2 ack after entry", {31'd0, grant_ack}, 32'd1);
    chk("R2 port released", {31'd0, tb_oe}, 32'd0);
  endtask

  task automatic normal_codes();
    req_a = 1'b0; req_b = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R3 reserved code no grant", {31'd0, grant_ack}, 32'd0);
    end
    req_a = 1'b0; req_b = 1'b0;
    @(negedge clk);
    chk("R3 idle code no grant", {31'd0, grant_ack}, 32'd0);
  endtask

  // called at a negedge with ack low; returns at negedge with ack high
  task automatic wait_access(input bit is_wr, input logic [31:0] wd, input int dly);
    int cnt = 0;
    forever begin
      chk("R8 ack low while busy", {31'd0, grant_ack}, 32'd0);
      req_a = 1'($urandom); req_b = 1'($urandom);   // R4: ignored
      if (m_valid) begin
        chk("R9 address held", m_addr, exp_addr);
        if (cnt >= dly) begin
          m_ready = 1'b1;
          m_rdata = rd_model(m_addr);
          hs_addr = m_addr;
          chk(is_wr ? "R6 write direction" : "R7 read direction",
              {31'd0, m_write}, {31'd0, is_wr});
          if (is_wr) chk("R6 write data", m_wdata, wd);
          if (is_wr && !last_rd) chk("R11 no drive on write", {31'd0, tb_oe}, 32'd0);
          @(negedge clk);
          m_ready = 1'b0;
          break;
        end
        cnt++;
      end
      @(negedge clk);
    end
    chk("R8 ack back after ready", {31'd0, grant_ack}, 32'd1);
    chk("R4 still in test mode", {31'd0, m_valid}, 32'd0);
    exp_addr = exp_addr + 32'd4;
  endtask

  task automatic do_addr(input logic [31:0] v);
    if (last_rd) begin
      req_a = 1'b1; req_b = 1'b1;
      @(negedge clk);
      chk("R11 turnaround releases port", {31'd0, tb_oe}, 32'd0);
      tb_in = ~v;                 // must not be loaded (R11)
      last_rd = 1'b0;
    end
    req_a = 1'b1; req_b = 1'b1;
    @(negedge clk);
    chk("R5 address vector not stretched", {31'd0, grant_ack}, 32'd1);
    tb_in = v;
    exp_addr = v;
  endtask

  task automatic do_write(input logic [31:0] v, input int dly);
    req_a = 1'b1; req_b = 1'b0;
    @(negedge clk);
    chk("R6 ack drops on write", {31'd0, grant_ack}, 32'd0);
    if (last_rd) begin
      chk("R10 port off after write code", {31'd0, tb_oe}, 32'd0);
      tb_in = ~v;                 // turnaround cycle, ignored (R11)
      req_a = 1'($urandom); req_b = 1'($urandom);
      @(negedge clk);
    end
    tb_in = v;
    wait_access(1'b1, v, dly);
    last_rd = 1'b0;
    chk("R10 port off after write", {31'd0, tb_oe}, 32'd0);
  endtask

  task automatic do_read(input int dly);
    req_a = 1'b0; req_b = 1'b1;
    @(negedge clk);
    chk("R7 ack drops on read", {31'd0, grant_ack}, 32'd0);
    if (last_rd) chk("R10 port stays on across reads", {31'd0, tb_oe}, 32'd1);
    tb_in = $urandom;
    wait_access(1'b0, 32'd0, dly);
    chk("R7 read data on port", tb_out, rd_model(hs_addr));
    chk("R7 port driven", {31'd0, tb_oe}, 32'd1);
    last_rd = 1'b1;
  endtask

  task automatic do_exit();
    req_a = 1'b0; req_b = 1'b0;
    @(negedge clk);
    chk("R12 ack low after exit", {31'd0, grant_ack}, 32'd0);
    chk("R12 port released after exit", {31'd0, tb_oe}, 32'd0);
    chk("R12 no transfer after exit", {31'd0, m_valid}, 32'd0);
    last_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired: actual=hang expected=completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_a = 1'b0; req_b = 1'b0;
    m_ready = 1'b0; m_rdata = '0; tb_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", {31'd0, grant_ack}, 32'd0);
    chk("R1 oe in reset", {31'd0, tb_oe}, 32'd0);
    chk("R1 valid in reset", {31'd0, m_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack after reset", {31'd0, grant_ack}, 32'd0);

    normal_codes();
    enter_test();

    // directed corner cases
    do_addr(32'h0000_1000);
    do_write(32'hCAFE_0001, 0);
    do_write(32'hCAFE_0002, 3);
    do_read(0);
    do_read(2);
    do_write(32'hBEEF_0003, 1);   // write right after read
    do_read(1);
    do_addr(32'h0000_2000);       // turnaround then address
    do_read(0);
    do_write(32'h1234_5678, 0);
    do_exit();
    normal_codes();
    enter_test();
    do_read(1);                   // address survives exit (R12)
    do_exit();
    enter_test();

    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      int d = $urandom_range(0, 3);
      if (k < 2)       do_addr($urandom & 32'hFFFF_FFFC);
      else if (k < 5)  do_write($urandom, d);
      else if (k < 9)  do_read(d);
      else begin
        do_exit();
        normal_codes();
        enter_test();
      end
    end
    do_exit();
    summary();
  end
endmodule